// File: doc/BRIEF.md
# Transmitter Configuration Loader and Mode Sequencer

This block takes a 32-bit setup word over a three-wire serial link (enable, data, serial clock) and then walks a transmitter through its power modes. It drives the enables of the crystal oscillator, the frequency synthesizer, the reference clock output driver and the power amplifier. It also counts out the synthesizer settling period in reference clock cycles. Once the last bit of the word is taken in, the serial data line no longer carries configuration: it becomes the transmit data input, and further serial clock activity has no effect.

All three link inputs pass through two-flop synchronisers into the reference clock domain. Serial clock edges are found there, so the serial clock must run well below the reference clock. A crystal-ready flag comes in as an input. A second entry path exists for reprogramming without stopping the oscillator: enable low with data high, held long enough, parks the block in a register-reset mode. From there a new word can be loaded.

Top module: `txcfg_mode_ctrl`

## Requirements
- R1: After reset, mode_o reads 0 (off) with every enable low and every field output zero. In the off mode the field outputs read zero.
- R2: Serial bits are taken on rising serial-clock edges, most significant first. The word is committed on the falling edge after the 32nd bit. Its layout is: [31] clock-only, [30] upper band, [29:15] frequency word, [14:7] deviation, [6] divide-by-4 select, [5:2] power level, [1] ASK (1) / FSK (0), [0] clock output enable.
- R3: Once a word is committed, further serial-clock activity leaves every field output unchanged.
- R4: From off (0), enable high with data low enters wake mode (1) with the oscillator enabled. Enable high with data high leaves the block in off.
- R5: In wake mode, after commit and only with crystal ready, the block enters synth mode (2) if clock-only is 0, or clock-only mode (5) if clock-only is 1. Without crystal ready it stays in wake mode.
- R6: Synth mode lasts exactly LOCK_CYCLES reference cycles before a transmit mode is entered. The synthesizer enable is high in synth, in both transmit modes and in config-B.
- R7: In a transmit mode, FSK, or ASK with data high, selects tx-on (4). ASK with data low selects tx-idle (3). The amplifier enable is high only in tx-on. mod_data_o follows the data line in the transmit modes.
- R8: Enable low with data low returns the block to off from any mode.
- R9: From any mode other than off and register-reset, enable low with data high held for RST_MIN_CYCLES cycles enters register-reset (6). In that mode only the oscillator (and clock driver, if allowed) stays on, and the field outputs keep their values. If enable rises before that count is reached, the block goes to off.
- R10: From register-reset, enable high with data low enters config-A (7). On the falling edge of the 2nd serial bit, with clock-only 0, the block enters config-B (8) with the synthesizer on. After commit and lock it enters a transmit mode.
- R11: The clock driver enable is high only when the clock-output-enable field is 1, crystal ready is high and the mode is neither off nor wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (crystal) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Link enable |
| sdin_i | input | 1 | Serial data / transmit data |
| sck_i | input | 1 | Serial clock |
| osc_ready_i | input | 1 | Crystal amplitude ready flag |
| mode_o | output | 4 | Current mode code |
| osc_en_o | output | 1 | Oscillator enable |
| synth_en_o | output | 1 | Synthesizer enable |
| clkdrv_en_o | output | 1 | Clock output driver enable |
| pa_en_o | output | 1 | Power amplifier enable |
| mod_data_o | output | 1 | Modulation data in transmit modes |
| clk_only_o | output | 1 | Clock-only field |
| band_hi_o | output | 1 | Upper band field |
| freq_o | output | 15 | Frequency word field |
| dev_o | output | 8 | Deviation field |
| clk_div4_o | output | 1 | Clock divider select field |
| pwr_o | output | 4 | Power level field |
| ask_o | output | 1 | ASK/FSK field |
| clk_out_en_o | output | 1 | Clock output enable field |

## Verification
The bench loads three distinct words: an FSK word with crystal ready already up, an ASK word through the register-reset path, and a clock-only word with crystal ready held low. These cover commit-then-advance, mid-word advance on the second bit, and the wait for crystal ready. A long and a short enable-low/data-high pulse show that the pulse length alone decides between register-reset and off. Extra serial clocks after commit, and data toggles in FSK versus ASK, show which line still matters after programming. A scoreboard of expected mode codes catches any extra or missing transition.

// File: rtl/txcfg_pkg.sv
package txcfg_pkg;

  typedef enum logic [3:0] {
    MODE_OFF     = 4'd0,
    MODE_WAKE    = 4'd1,
    MODE_SYNTH   = 4'd2,
    MODE_TX_IDLE = 4'd3,
    MODE_TX_ON   = 4'd4,
    MODE_CLK     = 4'd5,
    MODE_RST     = 4'd6,
    MODE_CFG_A   = 4'd7,
    MODE_CFG_B   = 4'd8
  } mode_e;

  // field order equals serial order, MSB first
  typedef struct packed {
    logic        clk_only;
    logic        band_hi;
    logic [14:0] freq;
    logic [7:0]  dev;
    logic        clk_div4;
    logic [3:0]  pwr;
    logic        ask;
    logic        clk_out_en;
  } cfg_t;

  localparam int unsigned CFG_BITS = $bits(cfg_t);

  function automatic cfg_t cfg_unpack(input logic [CFG_BITS-1:0] w);
    return cfg_t'(w);
  endfunction

  function automatic logic synth_active(input mode_e m);
    return (m == MODE_SYNTH) || (m == MODE_TX_IDLE) ||
           (m == MODE_TX_ON) || (m == MODE_CFG_B);
  endfunction

  function automatic logic clkdrv_allowed(input mode_e m);
    return (m != MODE_OFF) && (m != MODE_WAKE);
  endfunction

  function automatic logic sck_listen(input mode_e m);
    return (m == MODE_WAKE) || (m == MODE_CFG_A) || (m == MODE_CFG_B);
  endfunction

  function automatic logic is_tx(input mode_e m);
    return (m == MODE_TX_IDLE) || (m == MODE_TX_ON);
  endfunction

  function automatic mode_e tx_pick(input logic ask, input logic data);
    return (!ask || data) ? MODE_TX_ON : MODE_TX_IDLE;
  endfunction

endpackage

// File: rtl/txcfg_sync.sv
module txcfg_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg <= '0;
        else        stg <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/txcfg_shifter.sv
module txcfg_shifter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         listen_i,
  input  logic         sck_rise_i,
  input  logic         sck_fall_i,
  input  logic         sd_i,
  output logic [W-1:0] word_o,
  output logic         done_o,
  output logic         commit_evt_o,
  output logic         partial_evt_o,
  output logic         partial_msb_o
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL_CNT    = CW'(W);
  localparam logic [CW-1:0] PARTIAL_CNT = CW'(2);

  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;
  logic          done_q;
  logic          open_w;

  assign open_w        = listen_i && !done_q && !clear_i;
  assign commit_evt_o  = open_w && sck_fall_i && (cnt == FULL_CNT);
  assign partial_evt_o = open_w && sck_fall_i && (cnt == PARTIAL_CNT);
  assign partial_msb_o = shreg[1];
  assign word_o        = shreg;
  assign done_o        = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      cnt    <= '0;
      done_q <= 1'b0;
    end else if (clear_i) begin
      shreg  <= '0;
      cnt    <= '0;
      done_q <= 1'b0;
    end else if (open_w) begin
      if (sck_rise_i && (cnt < FULL_CNT)) begin
        shreg <= {shreg[W-2:0], sd_i};
        cnt   <= cnt + 1'b1;
      end
      if (commit_evt_o) done_q <= 1'b1;
    end
  end

  // R2
  bitcount_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  // R3
  frozen_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $past(done_q)) |-> $stable(shreg));
endmodule

// File: rtl/txcfg_lock_timer.sv
module txcfg_lock_timer #(
  parameter int unsigned LOCK_CYCLES = 1280
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic lock_hit_o
);
  localparam int unsigned TW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(LOCK_CYCLES - 1);

  logic [TW-1:0] cnt;

  assign lock_hit_o = run_i && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run_i)     cnt <= '0;
    else if (!lock_hit_o) cnt <= cnt + 1'b1;
  end

  // R6
  lock_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_hit_o && (LOCK_CYCLES > 1)) |-> $past(run_i));
endmodule

// File: rtl/txcfg_mode_ctrl.sv
module txcfg_mode_ctrl
  import txcfg_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES    = 1280,
  parameter int unsigned RST_MIN_CYCLES = 64,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  logic        sdin_i,
  input  logic        sck_i,
  input  logic        osc_ready_i,
  output logic [3:0]  mode_o,
  output logic        osc_en_o,
  output logic        synth_en_o,
  output logic        clkdrv_en_o,
  output logic        pa_en_o,
  output logic        mod_data_o,
  output logic        clk_only_o,
  output logic        band_hi_o,
  output logic [14:0] freq_o,
  output logic [7:0]  dev_o,
  output logic        clk_div4_o,
  output logic [3:0]  pwr_o,
  output logic        ask_o,
  output logic        clk_out_en_o
);
  localparam int unsigned RCW = $clog2(RST_MIN_CYCLES + 1);
  localparam logic [RCW-1:0] RST_LAST = RCW'(RST_MIN_CYCLES - 1);

  logic en_s, sd_s, sck_s, sck_d;
  logic sck_rise, sck_fall;

  txcfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({en_i, sdin_i, sck_i}),
    .q_o({en_s, sd_s, sck_s})
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;

  assign sck_rise = sck_s && !sck_d;
  assign sck_fall = !sck_s && sck_d;

  mode_e mode_q, mode_d;
  cfg_t  cfg_q;
  logic [RCW-1:0] rst_cnt_q, rst_cnt_d;

  logic [CFG_BITS-1:0] word_w;
  logic done_w, commit_evt, partial_evt, partial_msb;
  logic shift_clear, lock_run, lock_hit;
  logic active_w;

  assign shift_clear = (mode_q == MODE_OFF) || (mode_q == MODE_RST);

  txcfg_shifter #(.W(CFG_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .clear_i(shift_clear),
    .listen_i(sck_listen(mode_q)),
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall), .sd_i(sd_s),
    .word_o(word_w), .done_o(done_w),
    .commit_evt_o(commit_evt), .partial_evt_o(partial_evt),
    .partial_msb_o(partial_msb)
  );

  assign lock_run = ((mode_q == MODE_SYNTH) || (mode_q == MODE_CFG_B)) &&
                    done_w && osc_ready_i;

  txcfg_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .run_i(lock_run), .lock_hit_o(lock_hit)
  );

  assign active_w = (mode_q != MODE_OFF) && (mode_q != MODE_RST);

  always_comb begin
    mode_d    = mode_q;
    rst_cnt_d = '0;
    if (!en_s && !sd_s) begin
      mode_d = MODE_OFF;
    end else if (active_w && !en_s && sd_s) begin
      if (rst_cnt_q == RST_LAST) mode_d = MODE_RST;
      else                       rst_cnt_d = rst_cnt_q + 1'b1;
    end else if (active_w && (rst_cnt_q != '0)) begin
      mode_d = MODE_OFF;
    end else begin
      unique case (mode_q)
        MODE_OFF:   if (en_s && !sd_s) mode_d = MODE_WAKE;
        MODE_WAKE:  if (done_w && osc_ready_i)
                      mode_d = cfg_q.clk_only ? MODE_CLK : MODE_SYNTH;
        MODE_SYNTH, MODE_CFG_B:
                    if (lock_hit) mode_d = tx_pick(cfg_q.ask, sd_s);
        MODE_TX_IDLE, MODE_TX_ON:
                    mode_d = tx_pick(cfg_q.ask, sd_s);
        MODE_CLK:   mode_d = MODE_CLK;
        MODE_RST:   if (en_s && !sd_s) mode_d = MODE_CFG_A;
        MODE_CFG_A: begin
          if (partial_evt && !partial_msb)        mode_d = MODE_CFG_B;
          else if (done_w && osc_ready_i && cfg_q.clk_only) mode_d = MODE_CLK;
        end
        default:    mode_d = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_OFF;
      rst_cnt_q <= '0;
      cfg_q     <= '0;
    end else begin
      mode_q    <= mode_d;
      rst_cnt_q <= rst_cnt_d;
      if (mode_q == MODE_OFF) cfg_q <= '0;
      else if (commit_evt)    cfg_q <= cfg_unpack(word_w);
    end
  end

  assign mode_o       = mode_q;
  assign osc_en_o     = (mode_q != MODE_OFF);
  assign synth_en_o   = synth_active(mode_q);
  assign clkdrv_en_o  = clkdrv_allowed(mode_q) && cfg_q.clk_out_en && osc_ready_i;
  assign pa_en_o      = (mode_q == MODE_TX_ON);
  assign mod_data_o   = is_tx(mode_q) && sd_s;

  assign clk_only_o   = cfg_q.clk_only;
  assign band_hi_o    = cfg_q.band_hi;
  assign freq_o       = cfg_q.freq;
  assign dev_o        = cfg_q.dev;
  assign clk_div4_o   = cfg_q.clk_div4;
  assign pwr_o        = cfg_q.pwr;
  assign ask_o        = cfg_q.ask;
  assign clk_out_en_o = cfg_q.clk_out_en;

  // R8
  idle_lines_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s && !sd_s) |=> (mode_q == MODE_OFF));

  // R6
  tx_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_tx(mode_q) && (($past(mode_q) == MODE_SYNTH) || ($past(mode_q) == MODE_CFG_B)))
      |-> $past(lock_hit));

  // R9
  rst_entry_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_RST) && ($past(mode_q) != MODE_RST)) |-> ($past(rst_cnt_q) == RST_LAST));

  // R7
  pa_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_TX_ON) && ($past(mode_q) != MODE_TX_ON)) |->
      (($past(mode_q) == MODE_SYNTH) || ($past(mode_q) == MODE_CFG_B) ||
       ($past(mode_q) == MODE_TX_IDLE)));

  // R10
  cfgb_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_CFG_B) && ($past(mode_q) == MODE_CFG_A)) |-> $past(partial_evt));

  // R2
  commit_only_listening_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> (sck_listen(mode_q) && $past(sck_s)));
endmodule

// File: tb/txcfg_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module txcfg_mode_ctrl_tb_top;
  localparam int LOCK = 1280;
  localparam int RMIN = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, sd = 0, sck = 0, rdy = 0;
  logic [3:0] mode;
  logic osc_en, synth_en, clkdrv_en, pa_en, mod_data;
  logic clk_only, band_hi, div4, ask, clkon;
  logic [14:0] freq;
  logic [7:0] dev;
  logic [3:0] pwr;

  always #2.5 clk = ~clk;

  txcfg_mode_ctrl #(.LOCK_CYCLES(LOCK), .RST_MIN_CYCLES(RMIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .sdin_i(sd), .sck_i(sck),
    .osc_ready_i(rdy), .mode_o(mode), .osc_en_o(osc_en), .synth_en_o(synth_en),
    .clkdrv_en_o(clkdrv_en), .pa_en_o(pa_en), .mod_data_o(mod_data),
    .clk_only_o(clk_only), .band_hi_o(band_hi), .freq_o(freq), .dev_o(dev),
    .clk_div4_o(div4), .pwr_o(pwr), .ask_o(ask), .clk_out_en_o(clkon));

  int checks = 0, failures = 0;
  int cyc = 0;
  int t_enter [16];
  logic [3:0] expq [$];
  logic [3:0] last_mode = 4'd0;
  bit finished = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: each mode change must match the next expected code
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (mode !== last_mode) begin
        t_enter[mode] = cyc;
        checks++;
        if (expq.size() == 0) begin
          failures++;
          $display("FAIL R4-R10 mode sequence actual=%0d expected=none", mode);
        end else begin
          logic [3:0] e;
          e = expq.pop_front();
          if (e !== mode) begin
            failures++;
            $display("FAIL R4-R10 mode sequence actual=%0d expected=%0d", mode, e);
          end
        end
        last_mode = mode;
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_word(logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      sd = w[i]; tick(4);
      sck = 1;   tick(4);
      sck = 0;   tick(4);
    end
    tick(6);
  endtask

  function automatic logic [31:0] fields();
    return {clk_only, band_hi, freq, dev, div4, pwr, ask, clkon};
  endfunction

  // R2 layout: [31] clk-only [30] band [29:15] freq [14:7] dev [6] div4 [5:2] pwr [1] ask [0] clk-out
  function automatic logic [31:0] mk(logic co, logic bh, logic [14:0] f, logic [7:0] d,
                                     logic dv, logic [3:0] p, logic a, logic ce);
    logic [31:0] w;
    w[31] = co; w[30] = bh; w[29:15] = f; w[14:7] = d;
    w[6] = dv; w[5:2] = p; w[1] = a; w[0] = ce;
    return w;
  endfunction

  initial begin
    #500000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] w1, w2, w3;
    w1 = mk(1'b0, 1'b1, 15'd14342, 8'd100, 1'b1, 4'd8, 1'b0, 1'b1);
    w2 = mk(1'b0, 1'b0, 15'd3730, 8'd37, 1'b0, 4'd15, 1'b1, 1'b0);
    w3 = mk(1'b1, 1'b0, 15'd2500, 8'd1, 1'b1, 4'd3, 1'b0, 1'b1);

    tick(5); rst_n = 1; rdy = 1; tick(5);
    // R1 reset state
    check("R1 mode", {28'd0, mode}, 0);
    check("R1 enables", {27'd0, osc_en, synth_en, clkdrv_en, pa_en, mod_data}, 0);
    check("R1 fields", fields(), 0);

    // R4 wake, R2/R5/R6/R7 FSK load with ready high
    expq.push_back(4'd1); expq.push_back(4'd2); expq.push_back(4'd4);
    en = 1; sd = 0; tick(8);
    check("R4 wake mode", {28'd0, mode}, 1);
    check("R4 osc enable", {31'd0, osc_en}, 1);
    send_word(w1);
    check("R2 fields after load", fields(), w1);
    check("R2 freq field", {17'd0, freq}, 14342);
    check("R6 synth enable in synth", {31'd0, synth_en}, 1);
    tick(LOCK + 40);
    check("R6 synth dwell", t_enter[4] - t_enter[2], LOCK);
    check("R7 FSK tx-on", {28'd0, mode}, 4);
    check("R7 pa on", {31'd0, pa_en}, 1);
    check("R11 clk driver on", {31'd0, clkdrv_en}, 1);

    // R3 extra serial clocks after commit
    send_word(32'h5A5A_F0F0);
    check("R3 fields unchanged", fields(), w1);
    check("R7 FSK stays tx-on", {28'd0, mode}, 4);

    // R9 long reset-entry pulse
    expq.push_back(4'd6);
    en = 0; sd = 1; tick(RMIN + 20);
    check("R9 reg-reset mode", {28'd0, mode}, 6);
    check("R9 enables", {28'd0, osc_en, synth_en, pa_en, clkdrv_en}, 4'b1001);
    check("R9 fields kept", fields(), w1);

    // R10 config path with ASK word
    en = 1; tick(10);
    check("R10 waits for data low", {28'd0, mode}, 6);
    expq.push_back(4'd7);
    sd = 0; tick(10);
    check("R10 config-A", {28'd0, mode}, 7);
    expq.push_back(4'd8); expq.push_back(4'd3);
    send_word(w2);
    check("R10 config-B synth on", {27'd0, mode, synth_en}, {27'd0, 4'd8, 1'b1});
    tick(LOCK + 40);
    check("R10 ASK low tx-idle", {28'd0, mode}, 3);
    check("R7 pa off in tx-idle", {31'd0, pa_en}, 0);
    check("R2 ASK word fields", fields(), w2);
    check("R11 clk driver off by field", {31'd0, clkdrv_en}, 0);
    expq.push_back(4'd4);
    sd = 1; tick(8);
    check("R7 ASK high tx-on", {29'd0, mode[2:0] == 3'd4, pa_en, mod_data}, 3'b111);
    expq.push_back(4'd3);
    sd = 0; tick(8);
    check("R7 ASK low back", {30'd0, mode == 4'd3, mod_data}, 2'b10);

    // R9 short pulse goes to off; R1 fields cleared; R4 data-high stays off
    en = 0; sd = 1; tick(10);
    check("R9 held during short pulse", {28'd0, mode}, 3);
    expq.push_back(4'd0);
    en = 1; tick(8);
    check("R9 short pulse off", {28'd0, mode}, 0);
    check("R1 fields zero in off", fields(), 0);
    tick(8);
    check("R4 data high stays off", {28'd0, mode}, 0);
    expq.push_back(4'd1);
    sd = 0; tick(8);

    // R5 clock-only word, ready low first
    rdy = 0;
    send_word(w3);
    check("R5 waits for ready", {28'd0, mode}, 1);
    expq.push_back(4'd5);
    rdy = 1; tick(8);
    check("R5 clock-only mode", {28'd0, mode}, 5);
    check("R5 clock-only enables", {29'd0, synth_en, pa_en, clkdrv_en}, 3'b001);
    rdy = 0; tick(2);
    check("R11 driver needs ready", {31'd0, clkdrv_en}, 0);
    rdy = 1;
    expq.push_back(4'd0);
    en = 0; sd = 0; tick(8);
    check("R8 back to off", {30'd0, mode == 4'd0, osc_en}, 2'b10);
    check("R4-R10 scoreboard drained", expq.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule